// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is an interval timer with a small register port. Software programs a period, a prescale value and a start count, then sets the power and enable bits in the control word. While both bits are set, a prescaler divides the clock, and each prescaler tick lowers the count by one. When the count steps from one to zero, the timer raises a one-cycle interrupt pulse and sets a sticky expiry flag. The flag reads back in bit 3 of the control word.

In one-shot mode the count then stays at zero. With auto-reload set, the count is refilled from the period register and the timer keeps running. The timer itself never changes the period register. Writing zero to the control word stops the timer.

Top module: `tmr_core_timer`

## Requirements
- R1: After reset all four registers read zero and `irq_o` is low.
- R2: The register offsets are 0x0 for control, 0x4 for period, 0x8 for prescale and 0xC for count. A read at any other offset returns zero. The control bits are 0 power, 1 enable, 2 auto-reload and 3 expiry flag. The other control bits read zero.
- R3: While power and enable are not both set, the count does not change except by a write. Writes to period, prescale and count read back exactly as written.
- R4: While power and enable are both set, the count drops by one every prescale+1 clock cycles. The prescaler starts from zero when counting is switched on.
- R5: In one-shot mode the count holds at zero after it expires. Control reads back 0xB when 0x3 was written.
- R6: With auto-reload set, the count loads the period value on expiry and counting continues. Control reads back 0xF when 0x7 was written.
- R7: Each expiry, meaning a tick that finds the count at one, gives exactly one single-cycle `irq_o` pulse and sets the flag. A count that is already zero produces no expiry.
- R8: The flag stays set until a control write with bit 3 at 1 clears it. A control write with bit 3 at 0 leaves the flag unchanged. An expiry in the same cycle as a clearing write wins, and the flag stays set.
- R9: Writing zero to control clears power, enable and auto-reload, so counting stops.
- R10: A count write while running loads the new value on the next clock and restarts the prescaler.
- R11: The period register changes only when software writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe for this cycle |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Single-cycle pulse on each expiry |

## Verification
The hardest situations to reach from the ports are the ones where two events land on the same clock edge. Examples are a count write landing on the cycle a prescaler tick was due, a flag-clearing write landing on an expiry edge, and back-to-back expiries with auto-reload, a period of one and a prescale of zero. Directed sequences cover the one-shot and reload runs. A long seeded random phase then uses tiny counts, periods and prescale values so that expiries are frequent. Its writes often arrive mid-run, which makes such same-edge meetings common. Every read and every `irq_o` cycle is compared against the bench's cycle model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFF_CTRL  = 'h0;
  localparam int unsigned OFF_PER   = 'h4;
  localparam int unsigned OFF_SCALE = 'h8;
  localparam int unsigned OFF_CNT   = 'hC;

  localparam int unsigned BIT_PWR  = 0;
  localparam int unsigned BIT_EN   = 1;
  localparam int unsigned BIT_RLD  = 2;
  localparam int unsigned BIT_FLAG = 3;

  typedef struct packed {
    logic rld;
    logic en;
    logic pwr;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic [DATA_W-1:0] scale_i,
  output logic              tick_o
);
  logic [DATA_W-1:0] cnt_q;

  // >= keeps a shrunk scale from forcing a full wrap
  assign tick_o = run_i && !restart_i && (cnt_q >= scale_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i || restart_i)     cnt_q <= '0;
    else if (tick_o)                  cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  p_idle_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              tick_i,
  input  logic              reload_en_i,
  input  logic [DATA_W-1:0] period_i,
  output logic [DATA_W-1:0] count_o,
  output logic              expire_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] count_q;

  assign expire_o = !load_i && tick_i && (count_q == ONE);
  assign count_o  = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        count_q <= '0;
    else if (load_i)                    count_q <= load_val_i;
    else if (expire_o)                  count_q <= reload_en_i ? period_i : '0;
    else if (tick_i && count_q != '0)   count_q <= count_q - 1'b1;
  end

  p_hold_no_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(count_q));
  p_zero_sticks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && count_q == '0) |=> (count_q == '0));
  p_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && reload_en_i) |=> (count_q == $past(period_i)));
endmodule

// File: rtl/tmr_core_timer.sv
module tmr_core_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_PER   = ADDR_W'(OFF_PER);
  localparam logic [ADDR_W-1:0] A_SCALE = ADDR_W'(OFF_SCALE);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(OFF_CNT);

  ctrl_t             ctrl_q;
  logic              flag_q;
  logic [DATA_W-1:0] period_q, scale_q, count;
  logic              running, tick, expire;
  logic              ctrl_we, per_we, scale_we, cnt_we;

  assign ctrl_we  = we_i && (addr_i == A_CTRL);
  assign per_we   = we_i && (addr_i == A_PER);
  assign scale_we = we_i && (addr_i == A_SCALE);
  assign cnt_we   = we_i && (addr_i == A_CNT);
  assign running  = ctrl_q.pwr && ctrl_q.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
      period_q <= '0;
      scale_q  <= '0;
      irq_o    <= 1'b0;
    end else begin
      if (ctrl_we) begin
        ctrl_q.pwr <= wdata_i[BIT_PWR];
        ctrl_q.en  <= wdata_i[BIT_EN];
        ctrl_q.rld <= wdata_i[BIT_RLD];
      end
      // expiry beats a simultaneous clear
      if (expire)                             flag_q <= 1'b1;
      else if (ctrl_we && wdata_i[BIT_FLAG])  flag_q <= 1'b0;
      if (per_we)   period_q <= wdata_i;
      if (scale_we) scale_q  <= wdata_i;
      irq_o <= expire;
    end
  end

  tmr_prescaler #(.DATA_W(DATA_W)) i_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (running),
    .restart_i (cnt_we),
    .scale_i   (scale_q),
    .tick_o    (tick)
  );

  tmr_down_counter #(.DATA_W(DATA_W)) i_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (cnt_we),
    .load_val_i  (wdata_i),
    .tick_i      (tick),
    .reload_en_i (ctrl_q.rld),
    .period_i    (period_q),
    .count_o     (count),
    .expire_o    (expire)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[BIT_PWR]  = ctrl_q.pwr;
        rdata_o[BIT_EN]   = ctrl_q.en;
        rdata_o[BIT_RLD]  = ctrl_q.rld;
        rdata_o[BIT_FLAG] = flag_q;
      end
      A_PER:   rdata_o = period_q;
      A_SCALE: rdata_o = scale_q;
      A_CNT:   rdata_o = count;
      default: rdata_o = '0;
    endcase
  end

  p_irq_sets_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_q);
  p_period_owned_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !per_we |=> $stable(period_q));
  p_ctrl_zero_stops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && wdata_i[2:0] == 3'b000) |=> !running);
  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(ctrl_we && wdata_i[BIT_FLAG])) |=> flag_q);
endmodule

// File: tb/test_tmr_core_timer.sv
`timescale 1ns/1ps
module test_tmr_core_timer;
  localparam int DW = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_cmp = 0, n_bad = 0, irq_seen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_core_timer #(.DATA_W(DW), .ADDR_W(AW)) i_tmr_core_timer (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // cycle model from the requirements
  logic [2:0]    m_ctrl;
  logic          m_flag, m_irq;
  logic [DW-1:0] m_per, m_scale, m_cnt, m_pc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_flag <= 0; m_irq <= 0;
      m_per <= '0; m_scale <= '0; m_cnt <= '0; m_pc <= '0;
    end else begin
      bit run, cw, tk, ex;
      run = m_ctrl[0] && m_ctrl[1];
      cw  = we && addr == 8'hC;
      tk  = run && !cw && m_pc >= m_scale;
      ex  = tk && m_cnt == 1;
      m_pc <= (!run || cw || tk) ? '0 : m_pc + 1;
      if (cw) m_cnt <= wdata;
      else if (ex) m_cnt <= m_ctrl[2] ? m_per : '0;
      else if (tk && m_cnt != 0) m_cnt <= m_cnt - 1;
      if (ex) m_flag <= 1'b1;
      else if (we && addr == 8'h0 && wdata[3]) m_flag <= 1'b0;
      if (we && addr == 8'h0) m_ctrl <= wdata[2:0];
      if (we && addr == 8'h4) m_per <= wdata;
      if (we && addr == 8'h8) m_scale <= wdata;
      m_irq <= ex;
    end
  end

  function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
    case (a)
      8'h0: return {28'b0, m_flag, m_ctrl};
      8'h4: return m_per;
      8'h8: return m_scale;
      8'hC: return m_cnt;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R7 irq", {31'b0, irq}, {31'b0, m_irq});
    if (irq) irq_seen++;
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a);
    @(negedge clk); we = 0; addr = a; #1;
    check(req, rdata, model_rd(a));
  endtask

  task automatic rd_lit(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    @(negedge clk); we = 0; addr = a; #1;
    check(req, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #22 rst_n = 1;
    // R1 reset state, R2 map and unmapped offsets
    rd_lit("R1 ctrl", 8'h0, 0); rd_lit("R1 per", 8'h4, 0);
    rd_lit("R1 scale", 8'h8, 0); rd_lit("R1 cnt", 8'hC, 0);
    check("R1 irq", {31'b0, irq}, 0);
    // R3 powered, not enabled
    wr(8'h0, 32'h1); wr(8'h4, 32'h20); wr(8'hC, 32'h2); wr(8'h8, 32'h5);
    rd_lit("R2 per", 8'h4, 32'h20); rd_lit("R2 scale", 8'h8, 32'h5);
    wr(8'h10, 32'hFFFF); rd_lit("R2 unmapped 0x10", 8'h10, 0);
    rd_lit("R2 unmapped 0x6", 8'h6, 0);
    idle(10);
    rd_lit("R3 cnt held", 8'hC, 32'h2);
    // R4/R5/R7 one-shot: zero reached 12 cycles after the enable edge
    irq_seen = 0;
    wr(8'h0, 32'h3);   // edge E at first negedge+5
    idle(3);
    rd_lit("R4 cnt before first tick", 8'hC, 32'h2);
    idle(3);
    rd_lit("R4 cnt after first tick", 8'hC, 32'h1);
    idle(12);
    rd_lit("R5 cnt stays zero", 8'hC, 0);
    rd_lit("R5 ctrl 0xB", 8'h0, 32'hB);
    check("R7 one pulse", irq_seen, 1);
    // R9 off, R8 flag sticky then cleared
    wr(8'h0, 32'h0);
    rd_lit("R9 ctrl off keeps flag", 8'h0, 32'h8);
    wr(8'hC, 32'h4); idle(8);
    rd_lit("R9 no counting", 8'hC, 32'h4);
    wr(8'h0, 32'h8);
    rd_lit("R8 flag cleared", 8'h0, 0);
    // R6 auto-reload
    wr(8'h0, 32'h1); wr(8'h4, 32'h20); wr(8'hC, 32'h3); wr(8'h8, 32'h2);
    wr(8'h0, 32'h7);
    idle(20);
    rd_lit("R11 period kept", 8'h4, 32'h20);
    rd_lit("R6 ctrl 0xF", 8'h0, 32'hF);
    rd("R6 cnt reloaded", 8'hC);
    // R10 count write while running
    wr(8'hC, 32'h9);
    rd("R10 cnt loaded", 8'hC);
    idle(2); rd("R10 prescaler restart", 8'hC);
    wr(8'h0, 32'h3); idle(30);
    rd("R5 cnt after one-shot", 8'hC);
    wr(8'h0, 32'h8);
    // random phase
    for (int i = 0; i < 5000; i++) begin
      int op;
      op = $urandom % 10;
      if (op < 4) idle(1 + $urandom % 3);
      else if (op < 7) begin
        int r;
        r = $urandom % 4;
        case (r)
          0: wr(8'h0, $urandom % 16);
          1: wr(8'h4, $urandom % 6);
          2: wr(8'h8, $urandom % 3);
          default: wr(8'hC, $urandom % 8);
        endcase
      end else begin
        logic [AW-1:0] a;
        a = ($urandom % 8 == 0) ? 8'h14 : AW'(($urandom % 4) * 4);
        rd("R4 R6 R8 R10 random read", a);
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule